// File: doc/BRIEF.md
# Skip-Condition Next-PC Unit

This block keeps the program counter of a small word-addressed sequencer that never redirects fetch. Instruction words are always fetched in order. Conditional control flow comes only from skip instructions. When a skip is taken, the block marks the next one or two fetched words to be ignored. Nothing is ever flushed.

Each cycle the decoder presents the following:
- the class of the instruction at the current PC;
- two register operands;
- a vector of status flags;
- a bit index.

The block reports the effective address where useful execution resumes. It also raises a squash indication while the current word must be treated as a no-op.

The caller pulses `step_i` when the current instruction retires. The PC then advances by one word, modulo 2^PW_W. A taken skip loads a small squash counter. Each later retirement of a squashed word counts that counter down.

Top module: `skip_npc_unit`

## Requirements
- R1: After a synchronous active-high reset, `pc_o` is 0 and `squash_o` is 0.
- R2: Class code 0 (plain sequential), and the unused codes 6 and 7, never skip. For these, `npc_o` equals `pc_o` + 1.
- R3: Class code 1 compares `opa_i` with `opb_i`. When they are equal, it skips one word and `npc_o` is `pc_o` + 2. Otherwise `npc_o` is `pc_o` + 1.
- R4: Class code 2 skips one word when `opa_i` is zero.
- R5: Class code 3 skips one word when `flags_i[sel_i]` is 1. An index at or above FLAG_N never skips.
- R6: Class code 4 skips one word when bit `sel_i` of `opa_i` is 0.
- R7: Class code 5 compares `opa_i` with `opb_i` as two's-complement numbers:
  - `opa_i` greater: skips nothing (`npc_o` = `pc_o` + 1);
  - equal: skips one word (`npc_o` = `pc_o` + 2);
  - `opa_i` less: skips two words (`npc_o` = `pc_o` + 3).
- R8: With `step_i` high, `pc_o` advances by exactly 1 at the clock edge. With `step_i` low, `pc_o` and the squash state hold.
- R9: A taken skip of n words sets `squash_o` high for exactly the next n retired instructions. `squash_o` then returns low.
- R10: While `squash_o` is high, the inputs are not evaluated. `npc_o` is `pc_o` + 1, and retiring the word loads no new skip.
- R11: All PC arithmetic, including `npc_o`, wraps modulo 2^PW_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | Current instruction retires this cycle |
| cls_i | input | 3 | Instruction class code of the word at pc_o |
| opa_i | input | DATA_W | First register operand |
| opb_i | input | DATA_W | Second register operand |
| flags_i | input | FLAG_N | Status flag vector |
| sel_i | input | $clog2(DATA_W) | Bit index for bit-test and flag-test |
| pc_o | output | PW_W | Address of the current instruction |
| npc_o | output | PW_W | Effective address where execution resumes |
| squash_o | output | 1 | Current word is to be ignored |

## Verification
The hardest situation to reach is a skip-class instruction that arrives while an earlier skip is still squashing. It is hardest of all when a two-word compare skip overlaps further skip encodings. In that case the condition must be ignored, and the counter must run down rather than reload.

The random stimulus draws skip classes most of the time. It forces operand equality and negative values often, so that squash windows are routinely occupied by live-looking skips. Directed sequences also place a two-word skip directly ahead of two taken-condition words. Long runs wrap the 12-bit PC, and every cycle is compared with a bench model.

// File: rtl/skip_npc_pkg.sv
package skip_npc_pkg;

    typedef enum logic [2:0] {
        CLS_SEQ  = 3'd0,
        CLS_EQ   = 3'd1,
        CLS_ZERO = 3'd2,
        CLS_FLAG = 3'd3,
        CLS_BIT  = 3'd4,
        CLS_CMP3 = 3'd5
    } instr_cls_e;

    typedef logic [1:0] skip_amt_t;

    localparam skip_amt_t SKIP_NONE = 2'd0;
    localparam skip_amt_t SKIP_ONE  = 2'd1;
    localparam skip_amt_t SKIP_TWO  = 2'd2;

    typedef struct packed {
        logic      taken;
        skip_amt_t amt;
    } skip_dec_t;

    function automatic skip_dec_t mk_skip(input skip_amt_t a);
        skip_dec_t d;
        d.taken = (a != SKIP_NONE);
        d.amt   = a;
        return d;
    endfunction

endpackage

// File: rtl/skip_cond_eval.sv
module skip_cond_eval
    import skip_npc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int FLAG_N = 8,
    localparam int SEL_W = $clog2(DATA_W)
) (
    input  logic [2:0]        cls,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [FLAG_N-1:0] flags,
    input  logic [SEL_W-1:0]  sel,
    output skip_dec_t         dec
);
    logic flag_hit;
    logic bit_clear;
    logic ops_eq;
    logic ops_lt;

    // flag select, out-of-range index reads as 0
    always_comb begin
        flag_hit = 1'b0;
        for (int i = 0; i < FLAG_N; i++) begin
            if (int'(sel) == i) flag_hit = flags[i];
        end
    end

    assign bit_clear = ~opa[sel];
    assign ops_eq    = (opa == opb);
    assign ops_lt    = ($signed(opa) < $signed(opb));

    always_comb begin
        unique case (cls)
            CLS_EQ:   dec = mk_skip(ops_eq    ? SKIP_ONE : SKIP_NONE);
            CLS_ZERO: dec = mk_skip((opa == '0) ? SKIP_ONE : SKIP_NONE);
            CLS_FLAG: dec = mk_skip(flag_hit  ? SKIP_ONE : SKIP_NONE);
            CLS_BIT:  dec = mk_skip(bit_clear ? SKIP_ONE : SKIP_NONE);
            CLS_CMP3: dec = mk_skip(ops_lt ? SKIP_TWO : (ops_eq ? SKIP_ONE : SKIP_NONE));
            default:  dec = mk_skip(SKIP_NONE);
        endcase
    end

    // only the three-way compare may ask for two words (R7)
    always_comb begin
        if (dec.amt == SKIP_TWO)
            a_two_only_cmp_r7: assert (cls == CLS_CMP3);
        if (dec.amt == 2'd3)
            a_amt_legal_r7: assert (1'b0);
    end

endmodule

// File: rtl/squash_ctr.sv
module squash_ctr
    import skip_npc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      step,
    input  skip_dec_t dec,
    output logic      active
);
    skip_amt_t cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= SKIP_NONE;
        end else if (step) begin
            if (cnt_q != SKIP_NONE) cnt_q <= cnt_q - 2'd1;
            else                    cnt_q <= dec.amt;
        end
    end

    assign active = (cnt_q != SKIP_NONE);

    p_cnt_range_r9: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= SKIP_TWO);

    p_no_reload_r10: assert property (@(posedge clk) disable iff (rst)
        (step && cnt_q != SKIP_NONE) |=> (cnt_q == $past(cnt_q) - 2'd1));

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(cnt_q));

endmodule

// File: rtl/pc_reg.sv
module pc_reg #(
    parameter int PW_W = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            step,
    output logic [PW_W-1:0] pc
);
    always_ff @(posedge clk) begin
        if (rst)       pc <= '0;
        else if (step) pc <= pc + PW_W'(1);
    end

    p_pc_step_r8: assert property (@(posedge clk) disable iff (rst)
        step |=> (pc == $past(pc) + PW_W'(1)));

    p_pc_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(pc));

endmodule

// File: rtl/skip_npc_unit.sv
module skip_npc_unit
    import skip_npc_pkg::*;
#(
    parameter int PW_W   = 12,
    parameter int DATA_W = 16,
    parameter int FLAG_N = 8,
    localparam int SEL_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_i,
    input  logic [2:0]        cls_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic [FLAG_N-1:0] flags_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic [PW_W-1:0]   pc_o,
    output logic [PW_W-1:0]   npc_o,
    output logic              squash_o
);
    skip_dec_t raw_dec;
    skip_dec_t eff_dec;
    logic      squashing;

    skip_cond_eval #(.DATA_W(DATA_W), .FLAG_N(FLAG_N)) u_eval (
        .cls(cls_i), .opa(opa_i), .opb(opb_i),
        .flags(flags_i), .sel(sel_i), .dec(raw_dec)
    );

    // a squashed word must not evaluate its own condition
    assign eff_dec = squashing ? mk_skip(SKIP_NONE) : raw_dec;

    squash_ctr u_sq (
        .clk(clk), .rst(rst), .step(step_i),
        .dec(eff_dec), .active(squashing)
    );

    pc_reg #(.PW_W(PW_W)) u_pc (
        .clk(clk), .rst(rst), .step(step_i), .pc(pc_o)
    );

    assign npc_o    = pc_o + PW_W'(1) + PW_W'(eff_dec.amt);
    assign squash_o = squashing;

    p_squash_npc_r10: assert property (@(posedge clk) disable iff (rst)
        squash_o |-> (npc_o == pc_o + PW_W'(1)));

    p_squash_follows_r9: assert property (@(posedge clk) disable iff (rst)
        (step_i && !squash_o && npc_o != pc_o + PW_W'(1)) |=> squash_o);

endmodule

// File: tb/skip_npc_unit_bench.sv
module skip_npc_unit_bench;
    localparam int PW_W = 12, DATA_W = 16, FLAG_N = 8, SEL_W = 4;

    logic clk = 0, rst;
    logic step_i;
    logic [2:0] cls_i;
    logic [DATA_W-1:0] opa_i, opb_i;
    logic [FLAG_N-1:0] flags_i;
    logic [SEL_W-1:0] sel_i;
    logic [PW_W-1:0] pc_o, npc_o;
    logic squash_o;

    int n_chk = 0, n_fail = 0;
    logic [PW_W-1:0] m_pc;
    int m_cnt;
    logic seen_wrap = 0;

    always #10 clk = ~clk;

    skip_npc_unit u_skip_npc_unit (.*);

    function automatic int exp_amt(input logic [2:0] c, input logic [DATA_W-1:0] a,
                                   input logic [DATA_W-1:0] b, input logic [FLAG_N-1:0] f,
                                   input logic [SEL_W-1:0] s);
        case (c)
            3'd1: return (a == b) ? 1 : 0;
            3'd2: return (a == 0) ? 1 : 0;
            3'd3: return (s < FLAG_N && f[s]) ? 1 : 0;
            3'd4: return a[s] ? 0 : 1;
            3'd5: return ($signed(a) < $signed(b)) ? 2 : (a == b ? 1 : 0);
            default: return 0;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive at negedge, check mid-cycle, update model at posedge
    task automatic cyc(input logic st, input logic [2:0] c, input logic [DATA_W-1:0] a,
                       input logic [DATA_W-1:0] b, input logic [FLAG_N-1:0] f,
                       input logic [SEL_W-1:0] s, input string req);
        int amt;
        @(negedge clk);
        step_i = st; cls_i = c; opa_i = a; opb_i = b; flags_i = f; sel_i = s;
        #2;
        amt = (m_cnt != 0) ? 0 : exp_amt(c, a, b, f, s);
        check({req, " pc"}, int'(pc_o), int'(m_pc));
        check({req, " squash R9"}, int'(squash_o), int'(m_cnt != 0));
        if (m_cnt != 0) check("R10 npc", int'(npc_o), int'(PW_W'(m_pc + 1)));
        else check({req, " npc"}, int'(npc_o), int'(PW_W'(m_pc + 1 + amt)));
        @(posedge clk);
        if (st) begin
            if (m_pc == '1) seen_wrap = 1;
            m_pc = m_pc + 1;
            m_cnt = (m_cnt != 0) ? m_cnt - 1 : amt;
        end
    endtask

    initial begin
        #3_000_000;
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1; step_i = 0; cls_i = 0; opa_i = 0; opb_i = 0; flags_i = 0; sel_i = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0; #2;
        check("R1 pc reset", int'(pc_o), 0);
        check("R1 squash reset", int'(squash_o), 0);
        m_pc = 0; m_cnt = 0;

        // directed
        cyc(1, 3'd0, 16'h5, 16'h5, 8'hFF, 4'd0, "R2 seq");
        cyc(1, 3'd6, 16'h5, 16'h5, 8'hFF, 4'd0, "R2 code6");
        cyc(1, 3'd7, 0, 0, 8'hFF, 4'd0, "R2 code7");
        cyc(1, 3'd1, 16'h1234, 16'h1234, 0, 0, "R3 eq taken");
        cyc(1, 3'd1, 16'h1234, 16'h1234, 0, 0, "R10 squashed eq");
        cyc(1, 3'd1, 16'h1234, 16'h1235, 0, 0, "R3 ne");
        cyc(1, 3'd2, 16'h0, 16'h9, 0, 0, "R4 zero");
        cyc(1, 3'd0, 0, 0, 0, 0, "R4 shadow");
        cyc(1, 3'd2, 16'h8000, 0, 0, 0, "R4 nonzero");
        cyc(1, 3'd3, 0, 0, 8'h04, 4'd2, "R5 flag set");
        cyc(1, 3'd0, 0, 0, 0, 0, "R5 shadow");
        cyc(1, 3'd3, 0, 0, 8'hFB, 4'd2, "R5 flag clear");
        cyc(1, 3'd3, 0, 0, 8'hFF, 4'd9, "R5 out of range");
        cyc(1, 3'd4, 16'hFFDF, 0, 0, 4'd5, "R6 bit clear");
        cyc(1, 3'd0, 0, 0, 0, 0, "R6 shadow");
        cyc(1, 3'd4, 16'h0020, 0, 0, 4'd5, "R6 bit set");
        cyc(1, 3'd5, 16'h0003, 16'hFFFF, 0, 0, "R7 greater signed");
        cyc(1, 3'd5, 16'h8000, 16'h0001, 0, 0, "R7 less signed two");
        cyc(1, 3'd5, 16'h8000, 16'h0001, 0, 0, "R10 squash 1of2");
        cyc(0, 3'd1, 16'h1, 16'h1, 0, 0, "R8 hold");
        cyc(1, 3'd2, 16'h0, 16'h0, 0, 0, "R10 squash 2of2");
        cyc(1, 3'd5, 16'h7777, 16'h7777, 0, 0, "R7 equal one");
        cyc(0, 3'd0, 0, 0, 0, 0, "R8 hold squash");
        cyc(1, 3'd0, 0, 0, 0, 0, "R9 tail");

        // random, long enough to wrap the PC (R11)
        for (int i = 0; i < 9000; i++) begin
            logic [2:0] c; logic [DATA_W-1:0] a, b;
            c = 3'($urandom_range(0, 7));
            a = 16'($urandom);
            b = ($urandom_range(0, 2) == 0) ? a : 16'($urandom);
            if ($urandom_range(0, 5) == 0) a = 0;
            cyc(($urandom_range(0, 7) != 0), c, a, b, 8'($urandom), 4'($urandom), "R11 random");
        end
        check("R11 wrap seen", int'(seen_wrap), 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule